// File: doc/BRIEF.md
# Composite Video Raster Timing Generator

This block is the master timing source of a digital composite video encoder. It runs from a 27 MHz clock and holds a horizontal position counter in 27 MHz cycles and a line counter. From these two counters it derives every timing signal the rest of the encoder needs: an active-low composite sync, a horizontal sync output with a programmable position, a vertical sync output, a field flag, a vertical blanking gate, a colour-burst/clamp gate, a set-up (pedestal) gate and the 13.5 MHz pixel enable.

A select input chooses between 525-line and 625-line rasters. The choice is taken only at the end of a frame, so the raster never changes geometry in the middle of a field. A 10-bit offset register moves the falling edge of the horizontal sync output along the line. A new offset takes effect from the next line, and a pulse that would run past the end of a line is cut short there.

Top module: `rtg_raster_top`

## Requirements
- R1: `h_pos` counts 0 to T-1 and then restarts, where T is 1716 clocks per line in 525-line mode and 1728 in 625-line mode. `pix_en` is 1 when `h_pos` is even and 0 when it is odd.
- R2: `line_num` runs 1 to 525 (or 1 to 625) and advances when `h_pos` wraps. `std_625_sel` (1 = 625-line) is sampled only on the clock that ends the last line of a frame and is shown on `std_act`. Changes at other times have no effect.
- R3: While `rst_n` is low (asynchronous), the block shows line 64, `h_pos` 0, `csync_n` low, `vblank` 0, `field` 0, `std_act` 0, and an HS offset of 0x07E.
- R4: In 525-line mode, `vblank` is 1 on lines 1-9 and 264-272, and on line 263 once `h_pos` reaches T/2. It is 0 elsewhere.
- R5: In 625-line mode, `vblank` is 1 on lines 1-5, 311-318 and 624-625, and on line 623 once `h_pos` reaches T/2. It is 0 elsewhere.
- R6: `burst_gate` is 1 only while `h_pos` is in [BURST_START, BURST_START+BURST_LEN) on lines 10-263 or 273-525 (525-line mode), or on lines 6-310 or 319-623 (625-line mode).
- R7: `ped_gate` is 1 in the same cycle that `ped_en` is 1, but only in 525-line mode and only on lines 23-262 or 286-525. In 625-line mode it is always 0.
- R8: Let F = 2*offset, reduced by T if it is not below T. `hs_n` is low for `h_pos` in [F, F+HS_WIDTH) and is cut at the end of the line. A write on `hsoff_we` is held in a pending register and becomes active at the start of the line after the one in which the write registers.
- R9: `vs` marks the field sync interval, counted in half-lines. In 525-line mode it is lines 4-6, and from the second half of line 266 to the first half of line 269. In 625-line mode it is from line 1 to the first half of line 3, and from the second half of line 313 to the end of line 315.
- R10: `field` is 1 for the second field. It changes only where `vs` starts: to 0 at the start of the first field-sync interval and to 1 at the start of the second.
- R11: `csync_n` is low for the first HS_WIDTH clocks of every line. Inside a `vs` half-line it is instead low for the first T/2-HS_WIDTH clocks of that half-line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 27 MHz clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| std_625_sel | input | 1 | Requested raster: 1 = 625-line, 0 = 525-line |
| ped_en | input | 1 | Enable for the set-up gate |
| hsoff_we | input | 1 | Write strobe of the HS offset register |
| hsoff_wdata | input | 10 | New HS offset value |
| pix_en | output | 1 | 13.5 MHz pixel enable |
| h_pos | output | 12 | Horizontal position in 27 MHz clocks |
| line_num | output | 10 | Current line, starting at 1 |
| std_act | output | 1 | Raster in use: 1 = 625-line |
| csync_n | output | 1 | Composite sync, active low |
| hs_n | output | 1 | Horizontal sync, active low |
| vs | output | 1 | Field sync interval |
| field | output | 1 | Field flag, 1 = second field |
| vblank | output | 1 | Vertical blanking gate |
| burst_gate | output | 1 | Colour burst / clamp gate |
| ped_gate | output | 1 | Pedestal gate |

## Verification
All outputs are decoded from the two counters in the same cycle. A wrong counter value therefore appears on `h_pos` and `line_num` at once, and within a few lines on the gate that covers the affected line. The bench keeps its own position model and compares every output on every clock. It does this through a partial frame after reset, a full 525-line frame and a full 625-line frame, with a shortened line length. A mislatched standard, a wrong line-list boundary or a stale offset register is therefore reported on the first clock it differs. Random offset writes include values that wrap F past the line end and values that make the HS pulse shorter.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
    localparam int POS_W  = 12;
    localparam int LINE_W = 10;
    localparam int OFF_W  = 10;

    localparam logic [LINE_W-1:0] FRAME_525  = LINE_W'(525);
    localparam logic [LINE_W-1:0] FRAME_625  = LINE_W'(625);
    localparam logic [LINE_W-1:0] RESET_LINE = LINE_W'(64);

    typedef struct packed {
        logic [POS_W-1:0]  h;
        logic [LINE_W-1:0] line;
        logic              std;
    } raster_t;

    typedef struct packed {
        logic [OFF_W-1:0] pend;
        logic [OFF_W-1:0] act;
    } hsoff_t;

    function automatic logic in_rng(input logic [LINE_W-1:0] v, input int lo, input int hi);
        return (int'(v) >= lo) && (int'(v) <= hi);
    endfunction
endpackage

// File: rtl/rtg_hv_counter.sv
module rtg_hv_counter
    import rtg_pkg::*;
#(
    parameter int H_TOTAL_525 = 1716,
    parameter int H_TOTAL_625 = 1728
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    std_req,
    output raster_t pos_o,
    output logic    line_end_o
);
    localparam logic [POS_W-1:0] LAST_525 = POS_W'(H_TOTAL_525 - 1);
    localparam logic [POS_W-1:0] LAST_625 = POS_W'(H_TOTAL_625 - 1);

    raster_t pos_d, pos_q;
    logic    line_end;

    always_comb begin
        pos_d    = pos_q;
        line_end = (pos_q.h == (pos_q.std ? LAST_625 : LAST_525));
        if (line_end) begin
            pos_d.h = '0;
            if (pos_q.line == (pos_q.std ? FRAME_625 : FRAME_525)) begin
                pos_d.line = LINE_W'(1);
                pos_d.std  = std_req;
            end else begin
                pos_d.line = pos_q.line + LINE_W'(1);
            end
        end else begin
            pos_d.h = pos_q.h + POS_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q.h    <= '0;
            pos_q.line <= RESET_LINE;
            pos_q.std  <= 1'b0;
        end else begin
            pos_q <= pos_d;
        end
    end

    assign pos_o      = pos_q;
    assign line_end_o = line_end;
endmodule

// File: rtl/rtg_line_decode.sv
module rtg_line_decode
    import rtg_pkg::*;
(
    input  logic              std,
    input  logic [LINE_W-1:0] line,
    input  logic              upper,
    input  logic              ped_en,
    output logic              vblank_o,
    output logic              burst_line_o,
    output logic              ped_line_o,
    output logic              vs_o,
    output logic              field_o
);
    always_comb begin
        if (!std) begin
            vblank_o     = in_rng(line, 1, 9) || in_rng(line, 264, 272)
                         || (in_rng(line, 263, 263) && upper);
            burst_line_o = in_rng(line, 10, 263) || in_rng(line, 273, 525);
            ped_line_o   = ped_en && (in_rng(line, 23, 262) || in_rng(line, 286, 525));
            vs_o         = in_rng(line, 4, 6) || in_rng(line, 267, 268)
                         || (in_rng(line, 266, 266) && upper)
                         || (in_rng(line, 269, 269) && !upper);
            field_o      = !(in_rng(line, 4, 265) || (in_rng(line, 266, 266) && !upper));
        end else begin
            vblank_o     = in_rng(line, 1, 5) || in_rng(line, 311, 318)
                         || in_rng(line, 624, 625) || (in_rng(line, 623, 623) && upper);
            burst_line_o = in_rng(line, 6, 310) || in_rng(line, 319, 623);
            ped_line_o   = 1'b0;
            vs_o         = in_rng(line, 1, 2) || (in_rng(line, 3, 3) && !upper)
                         || (in_rng(line, 313, 313) && upper) || in_rng(line, 314, 315);
            field_o      = in_rng(line, 314, 625) || (in_rng(line, 313, 313) && upper);
        end
    end
endmodule

// File: rtl/rtg_hs_gen.sv
module rtg_hs_gen
    import rtg_pkg::*;
#(
    parameter int               H_TOTAL_525 = 1716,
    parameter int               H_TOTAL_625 = 1728,
    parameter int               HS_WIDTH    = 128,
    parameter logic [OFF_W-1:0] HSOFF_RST   = 10'h07E
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [OFF_W-1:0] wr_data,
    input  logic             std,
    input  logic [POS_W-1:0] h,
    input  logic             line_end,
    output logic             hs_n_o
);
    localparam int EW = POS_W + 1;

    hsoff_t        off_d, off_q;
    logic [EW-1:0] total, twice, fall, stop, h_ext;

    always_comb begin
        off_d = off_q;
        if (line_end) off_d.act  = off_q.pend;
        if (wr_en)    off_d.pend = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_q.pend <= HSOFF_RST;
            off_q.act  <= HSOFF_RST;
        end else begin
            off_q <= off_d;
        end
    end

    always_comb begin
        total  = std ? EW'(H_TOTAL_625) : EW'(H_TOTAL_525);
        twice  = EW'({off_q.act, 1'b0});
        fall   = (twice >= total) ? (twice - total) : twice;
        stop   = fall + EW'(HS_WIDTH);
        h_ext  = EW'(h);
        hs_n_o = !((h_ext >= fall) && (h_ext < stop));
    end
endmodule

// File: rtl/rtg_raster_top.sv
module rtg_raster_top
    import rtg_pkg::*;
#(
    parameter int               H_TOTAL_525 = 1716,
    parameter int               H_TOTAL_625 = 1728,
    parameter int               HS_WIDTH    = 128,
    parameter int               BURST_START = 148,
    parameter int               BURST_LEN   = 68,
    parameter logic [OFF_W-1:0] HSOFF_RST   = 10'h07E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              std_625_sel,
    input  logic              ped_en,
    input  logic              hsoff_we,
    input  logic [OFF_W-1:0]  hsoff_wdata,
    output logic              pix_en,
    output logic [POS_W-1:0]  h_pos,
    output logic [LINE_W-1:0] line_num,
    output logic              std_act,
    output logic              csync_n,
    output logic              hs_n,
    output logic              vs,
    output logic              field,
    output logic              vblank,
    output logic              burst_gate,
    output logic              ped_gate
);
    localparam logic [POS_W-1:0] HALF_525 = POS_W'(H_TOTAL_525 / 2);
    localparam logic [POS_W-1:0] HALF_625 = POS_W'(H_TOTAL_625 / 2);
    localparam logic [POS_W-1:0] SYNC_W   = POS_W'(HS_WIDTH);
    localparam logic [POS_W-1:0] B_FIRST  = POS_W'(BURST_START);
    localparam logic [POS_W-1:0] B_STOP   = POS_W'(BURST_START + BURST_LEN);

    raster_t          pos;
    logic             line_end, upper, burst_line, ped_line, vs_int;
    logic [POS_W-1:0] half, h_in_half;

    rtg_hv_counter #(
        .H_TOTAL_525(H_TOTAL_525),
        .H_TOTAL_625(H_TOTAL_625)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .std_req   (std_625_sel),
        .pos_o     (pos),
        .line_end_o(line_end)
    );

    assign half  = pos.std ? HALF_625 : HALF_525;
    assign upper = (pos.h >= half);

    rtg_line_decode u_dec (
        .std         (pos.std),
        .line        (pos.line),
        .upper       (upper),
        .ped_en      (ped_en),
        .vblank_o    (vblank),
        .burst_line_o(burst_line),
        .ped_line_o  (ped_line),
        .vs_o        (vs_int),
        .field_o     (field)
    );

    rtg_hs_gen #(
        .H_TOTAL_525(H_TOTAL_525),
        .H_TOTAL_625(H_TOTAL_625),
        .HS_WIDTH   (HS_WIDTH),
        .HSOFF_RST  (HSOFF_RST)
    ) u_hs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (hsoff_we),
        .wr_data (hsoff_wdata),
        .std     (pos.std),
        .h       (pos.h),
        .line_end(line_end),
        .hs_n_o  (hs_n)
    );

    always_comb begin
        h_in_half = upper ? (pos.h - half) : pos.h;
        if (vs_int) csync_n = !(h_in_half < (half - SYNC_W));
        else        csync_n = !(pos.h < SYNC_W);
    end

    assign burst_gate = burst_line && (pos.h >= B_FIRST) && (pos.h < B_STOP);
    assign ped_gate   = ped_line;
    assign vs         = vs_int;
    assign pix_en     = !pos.h[0];
    assign h_pos      = pos.h;
    assign line_num   = pos.line;
    assign std_act    = pos.std;
endmodule

// File: rtl/rtg_raster_chk.sv
module rtg_raster_chk
    import rtg_pkg::*;
#(
    parameter int H_TOTAL_525 = 1716,
    parameter int H_TOTAL_625 = 1728,
    parameter int HS_WIDTH    = 128
) (
    input logic              clk,
    input logic              rst_n,
    input logic              std_act,
    input logic [POS_W-1:0]  h_pos,
    input logic [LINE_W-1:0] line_num,
    input logic              pix_en,
    input logic              csync_n,
    input logic              hs_n,
    input logic              vs,
    input logic              field,
    input logic              vblank,
    input logic              burst_gate,
    input logic              ped_gate
);
    logic             started;
    logic [POS_W-1:0] low_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            started <= 1'b0;
            low_q   <= '0;
        end else begin
            started <= 1'b1;
            if (hs_n)             low_q <= '0;
            else if (h_pos == '0) low_q <= POS_W'(1);
            else                  low_q <= low_q + POS_W'(1);
        end
    end

    p_hpos_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        int'(h_pos) < (std_act ? H_TOTAL_625 : H_TOTAL_525));
    p_pix_toggle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        started |-> (pix_en != $past(pix_en)));
    p_line_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (started && h_pos != '0) |-> (line_num == $past(line_num) && h_pos == $past(h_pos) + POS_W'(1)));
    p_std_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (started && std_act != $past(std_act)) |-> (h_pos == '0 && line_num == LINE_W'(1)));
    p_burst_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        burst_gate |-> !vblank);
    p_ped_active_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ped_gate |-> (!vblank && !std_act));
    p_hs_width_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!hs_n && h_pos != '0) |-> (int'(low_q) < HS_WIDTH));
    p_vs_blank_r9: assert property (@(posedge clk) disable iff (!rst_n)
        vs |-> vblank);
    p_field_on_vs_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (started && field != $past(field)) |-> $rose(vs));
    p_sync_lead_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (h_pos == '0) |-> !csync_n);
endmodule

bind rtg_raster_top rtg_raster_chk #(
    .H_TOTAL_525(H_TOTAL_525),
    .H_TOTAL_625(H_TOTAL_625),
    .HS_WIDTH   (HS_WIDTH)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .std_act   (std_act),
    .h_pos     (h_pos),
    .line_num  (line_num),
    .pix_en    (pix_en),
    .csync_n   (csync_n),
    .hs_n      (hs_n),
    .vs        (vs),
    .field     (field),
    .vblank    (vblank),
    .burst_gate(burst_gate),
    .ped_gate  (ped_gate)
);

// File: tb/rtg_raster_top_test.sv
module rtg_raster_top_test;
    localparam int CLK_PERIOD = 38;
    localparam int T525       = 64;
    localparam int T625       = 68;
    localparam int HSW        = 8;
    localparam int BST        = 12;
    localparam int BLN        = 6;
    localparam int OFF_RST    = 20;
    localparam int WD_LIMIT   = 160000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       std_625_sel = 1'b0;
    logic       ped_en = 1'b1;
    logic       hsoff_we = 1'b0;
    logic [9:0] hsoff_wdata = '0;
    logic       pix_en, std_act, csync_n, hs_n, vs, field, vblank, burst_gate, ped_gate;
    logic [11:0] h_pos;
    logic [9:0]  line_num;

    rtg_raster_top #(
        .H_TOTAL_525(T525), .H_TOTAL_625(T625), .HS_WIDTH(HSW),
        .BURST_START(BST), .BURST_LEN(BLN), .HSOFF_RST(10'(OFF_RST))
    ) uut (
        .clk(clk), .rst_n(rst_n), .std_625_sel(std_625_sel), .ped_en(ped_en),
        .hsoff_we(hsoff_we), .hsoff_wdata(hsoff_wdata), .pix_en(pix_en),
        .h_pos(h_pos), .line_num(line_num), .std_act(std_act), .csync_n(csync_n),
        .hs_n(hs_n), .vs(vs), .field(field), .vblank(vblank),
        .burst_gate(burst_gate), .ped_gate(ped_gate)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_cmp = 0, n_bad = 0, frames = 0;
    int m_h, m_line, m_std, m_pend, m_act;
    bit done = 0;

    function automatic int tot(int s); return s ? T625 : T525; endfunction
    function automatic int hl_of(int s, int ln, int h);
        return 2 * (ln - 1) + ((h >= tot(s) / 2) ? 1 : 0);
    endfunction
    function automatic bit e_vblank(int s, int ln, int h);
        int hl = hl_of(s, ln, h);
        if (!s) return (hl <= 17) || (hl >= 525 && hl <= 543);
        return (hl <= 9) || (hl >= 620 && hl <= 635) || (hl >= 1245);
    endfunction
    function automatic bit e_vs(int s, int ln, int h);
        int hl = hl_of(s, ln, h);
        if (!s) return (hl >= 6 && hl <= 11) || (hl >= 531 && hl <= 536);
        return (hl <= 4) || (hl >= 625 && hl <= 629);
    endfunction
    function automatic bit e_field(int s, int ln, int h);
        int hl = hl_of(s, ln, h);
        if (!s) return !(hl >= 6 && hl <= 530);
        return hl >= 625;
    endfunction
    function automatic bit e_burst(int s, int ln, int h);
        bit on_line = s ? ((ln >= 6 && ln <= 310) || (ln >= 319 && ln <= 623))
                        : ((ln >= 10 && ln <= 263) || (ln >= 273 && ln <= 525));
        return on_line && h >= BST && h < BST + BLN;
    endfunction
    function automatic bit e_ped(int s, int ln, bit p);
        return p && !s && ((ln >= 23 && ln <= 262) || (ln >= 286 && ln <= 525));
    endfunction
    function automatic bit e_hs_n(int s, int h, int off);
        int f = 2 * off;
        if (f >= tot(s)) f = f - tot(s);
        return !(h >= f && h < f + HSW);
    endfunction
    function automatic bit e_csync_n(int s, int ln, int h);
        int half = tot(s) / 2;
        int hin = (h >= half) ? h - half : h;
        if (e_vs(s, ln, h)) return !(hin < half - HSW);
        return !(h < HSW);
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s line=%0d h=%0d actual=%0d expected=%0d",
                     tag, what, m_line, m_h, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("R1", "h_pos", int'(h_pos), m_h);
        chk("R1", "pix_en", int'(pix_en), int'(m_h % 2 == 0));
        chk("R2", "line_num", int'(line_num), m_line);
        chk("R2", "std_act", int'(std_act), m_std);
        chk(m_std ? "R5" : "R4", "vblank", int'(vblank), int'(e_vblank(m_std, m_line, m_h)));
        chk("R6", "burst_gate", int'(burst_gate), int'(e_burst(m_std, m_line, m_h)));
        chk("R7", "ped_gate", int'(ped_gate), int'(e_ped(m_std, m_line, ped_en)));
        chk("R8", "hs_n", int'(hs_n), int'(e_hs_n(m_std, m_h, m_act)));
        chk("R9", "vs", int'(vs), int'(e_vs(m_std, m_line, m_h)));
        chk("R10", "field", int'(field), int'(e_field(m_std, m_line, m_h)));
        chk("R11", "csync_n", int'(csync_n), int'(e_csync_n(m_std, m_line, m_h)));
    endtask

    task automatic model_reset();
        m_h = 0; m_line = 64; m_std = 0; m_pend = OFF_RST; m_act = OFF_RST;
    endtask

    task automatic reset_checks();
        chk("R3", "h_pos", int'(h_pos), 0);
        chk("R3", "line_num", int'(line_num), 64);
        chk("R3", "csync_n", int'(csync_n), 0);
        chk("R3", "vblank", int'(vblank), 0);
        chk("R3", "field", int'(field), 0);
        chk("R3", "std_act", int'(std_act), 0);
        chk("R3", "hs_n", int'(hs_n), int'(e_hs_n(0, 0, OFF_RST)));
    endtask

    task automatic drive_stim();
        int last_h = tot(m_std) - 1;
        int last_line = m_std ? 625 : 525;
        hsoff_we = ($urandom_range(0, 399) == 0);
        if (hsoff_we) begin
            case ($urandom_range(0, 3))
                0: hsoff_wdata = 10'd0;
                1: hsoff_wdata = 10'd31;   // R8 pulse cut at line end
                2: hsoff_wdata = 10'd63;   // R8 fall position wraps
                default: hsoff_wdata = 10'($urandom_range(0, 63));
            endcase
        end
        // R2: mid-frame toggling must be ignored; value at frame end decides
        if (m_line == last_line && m_h >= last_h - 3) std_625_sel = (frames == 1);
        else std_625_sel = 1'($urandom_range(0, 1));
        if ($urandom_range(0, 999) == 0) ped_en = !ped_en;
    endtask

    task automatic advance();
        int last_h = tot(m_std) - 1;
        int last_line = m_std ? 625 : 525;
        if (m_h == last_h) m_act = m_pend;
        if (hsoff_we) m_pend = int'(hsoff_wdata);
        if (m_h == last_h) begin
            m_h = 0;
            if (m_line == last_line) begin
                m_line = 1; m_std = int'(std_625_sel); frames++;
            end else m_line++;
        end else m_h++;
    endtask

    task automatic step();
        drive_stim();
        advance();
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        void'($urandom(32'd19937));
        model_reset();
        repeat (3) @(negedge clk);
        reset_checks();
        rst_n = 1'b1;
        while (!(frames == 3 && m_line == 30)) step();
        // directed asynchronous reset in mid-line
        hsoff_we = 1'b0;
        @(negedge clk);
        #2 rst_n = 1'b0;
        #1 model_reset();
        reset_checks();
        @(negedge clk);
        rst_n = 1'b1;
        repeat (300) step();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (WD_LIMIT) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R2 watchdog expired actual=%0d expected=%0d", frames, 3);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule